// File: doc/BRIEF.md
# Idle-Based Elastic Buffer

This block is a clock-correction FIFO for one receive port. Octets arrive, each with a control flag, on the recovered receive clock. They leave on the local core clock. The memory is 128 entries deep by default. The two sides exchange their pointers as Gray codes through multi-stage synchronizers.

The two clocks differ slightly in frequency. The buffer absorbs the difference by working on whole idle ordered sets:

- When the buffer runs too full, the write side discards a complete idle pair.
- When it runs too empty, the read side emits an extra idle pair.

A two-octet idle is never split in either direction. A mode input selects which idle may be added or removed:

| Mode input | Idle used | First octet | Second octet |
|---|---|---|---|
| low (disparity not checked) | /I1/ | K28.5 = 0xBC, control flag set | 0xC5, control flag clear |
| high (disparity checked) | /I2/ | K28.5 = 0xBC, control flag set | 0x50, control flag clear |

The write side keeps a one-octet look-ahead register, so that it can see a whole pair before it decides to drop it. The read side starts only once enough data has accumulated. If a correction cannot keep up, a sticky status flag records the failure on each side.

Top module: `idle_elastic_buf`

## Requirements
- R1: After reset, `rd_valid`, `rd_data`, `rd_is_k`, `wr_overflow` and `rd_underflow` are all zero.
- R2: Octets that are not removed leave in the order they were written, with data and control flag unchanged. Each octet enters the memory when the next written octet arrives (one-octet look-ahead).
- R3: A write never overwrites unread data. An octet that finds the memory full is discarded and sets `wr_overflow`. The flag stays set until reset.
- R4: When write-side occupancy exceeds `HIGH_MARK`, the write side drops a complete idle of the selected type. The idle is 0xBC with `wr_is_k`=1, followed by 0xC5 (`disp_chk`=0) or 0x50 (`disp_chk`=1) with `wr_is_k`=0. The rest of the data is not disturbed.
- R5: An idle whose second octet belongs to the other mode is never deleted.
- R6: While running, with read-side occupancy below `LOW_MARK` and an 0xBC control octet at the head, the read side first emits 0xBC with `rd_is_k`=1. On the next cycle it emits the mode's second octet with `rd_is_k`=0. Only then does it output the head. Each head octet gets at most one insertion.
- R7: `rd_valid` stays low until read-side occupancy has reached `LOW_MARK` once after reset.
- R8: Once running, a read cycle that finds the buffer empty drives `rd_valid` low and sets `rd_underflow`. The flag stays set until reset.
- R9: Each exchanged pointer changes in at most one bit per clock of its own domain.
- R10: Every 0xBC control octet on the read side is immediately followed by a valid idle second octet, because pairs are only ever added or removed whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | An octet is present this cycle |
| wr_data | input | 8 | Incoming octet |
| wr_is_k | input | 1 | Incoming octet is a control character |
| disp_chk | input | 1 | Quasi-static mode: 0 corrects with /I1/, 1 with /I2/ |
| wr_overflow | output | 1 | Sticky: an octet was lost to a full memory |
| rd_clk | input | 1 | Local core clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_valid | output | 1 | An octet is presented this cycle |
| rd_data | output | 8 | Outgoing octet |
| rd_is_k | output | 1 | Outgoing octet is a control character |
| rd_underflow | output | 1 | Sticky: a read found the buffer empty |

## Verification
The embedded assertions watch, on every cycle:

- the single-bit steps of both Gray pointers;
- the occupancy bound seen by each side;
- that a dropped pair removes both octets with no write;
- the two-cycle shape of every inserted idle;
- the silence of the read port while priming;
- the stickiness of both status flags.

Only the bench's scenarios can show the end-to-end effects. With a slower reader, whole idles of the selected type disappear and nothing else is lost. With a faster reader, idles of the selected type appear even when the input carried only the other kind. An idle of the wrong type is kept, so the buffer overflows.

// File: rtl/eb_pkg.sv
`timescale 1ns/1ps
package eb_pkg;
  // One transported symbol: control flag plus octet value.
  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } octet_t;

  typedef enum logic [1:0] {
    RD_PRIME = 2'd0,   // waiting for the first fill to reach the low mark
    RD_RUN   = 2'd1,   // streaming, insertion allowed
    RD_INS   = 2'd2    // emitting the second octet of an inserted idle
  } rd_state_t;

  localparam logic [7:0] COMMA_K285 = 8'hBC;
  localparam logic [7:0] SEC_D56    = 8'hC5;
  localparam logic [7:0] SEC_D162   = 8'h50;

  // Second octet of the idle that correction may touch in the given mode.
  function automatic logic [7:0] idle_second(input logic disp_on);
    return disp_on ? SEC_D162 : SEC_D56;
  endfunction

  function automatic logic is_comma(input octet_t o);
    return o.k && (o.d == COMMA_K285);
  endfunction
endpackage

// File: rtl/eb_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a Gray-coded pointer or a quasi-static level.
module eb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eb_ram.sv
`timescale 1ns/1ps
// Simple dual-port storage: synchronous write on the receive clock,
// asynchronous read addressed from the core clock domain (distributed RAM).
module eb_ram
  import eb_pkg::*;
#(
  parameter  int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  octet_t        wdata,
  input  logic [AW-1:0] raddr,
  output octet_t        rdata
);
  octet_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eb_wr_ctrl.sv
`timescale 1ns/1ps
// Write-side control: one-octet look-ahead, idle-pair deletion above the
// high mark, full protection and the sticky overflow flag.
module eb_wr_ctrl
  import eb_pkg::*;
#(
  parameter  int DEPTH     = 128,
  parameter  int HIGH_MARK = 96,
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  octet_t        in_oct,
  input  logic          disp_on,
  input  logic [PW-1:0] rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output octet_t        mem_wdata,
  output logic [PW-1:0] wgray,
  output logic          overflow
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HIGH_P  = PW'(HIGH_MARK);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, occ;
  octet_t        hold;
  logic          hold_v;
  logic          drop_pair, push, full;

  always_comb begin
    rbin_s    = g2b(rgray_s);
    occ       = wbin - rbin_s;          // pessimistic: read pointer is stale
    full      = (occ == DEPTH_P);
    // A complete idle of the selected type, held octet first, incoming second.
    drop_pair = in_valid && hold_v && is_comma(hold) && !in_oct.k &&
                (in_oct.d == idle_second(disp_on)) && (occ > HIGH_P);
    push      = in_valid && hold_v && !drop_pair;
    mem_we    = push && !full;
    wbin_nxt  = wbin + PW'(mem_we);
  end

  assign mem_waddr = wbin[AW-1:0];
  assign mem_wdata = hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin     <= '0;
      wgray    <= '0;
      hold     <= '0;
      hold_v   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= b2g(wbin_nxt);
      if (push && full) overflow <= 1'b1;
      if (in_valid) begin
        if (drop_pair) begin
          hold_v <= 1'b0;
        end else begin
          hold   <= in_oct;
          hold_v <= 1'b1;
        end
      end
    end
  end

  assert_wgray_step_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_wocc_bound_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= DEPTH_P);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // Both octets of a deleted idle vanish: nothing held, nothing written.
  assert_drop_whole_R10: assert property (@(posedge clk) disable iff (rst)
    drop_pair |=> (!hold_v && (wbin == $past(wbin))));
endmodule

// File: rtl/eb_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side control: priming, idle-pair insertion below the low mark,
// registered output and the sticky underflow flag.
module eb_rd_ctrl
  import eb_pkg::*;
#(
  parameter  int DEPTH    = 128,
  parameter  int LOW_MARK = 32,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  octet_t        head,
  input  logic          disp_on,
  input  logic [PW-1:0] wgray_s,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          out_valid,
  output octet_t        out_oct,
  output logic          underflow
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] LOW_P   = PW'(LOW_MARK);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  rd_state_t     state;
  logic [PW-1:0] rbin, wbin_s, occ, rbin_inc;
  logic          empty, low, ins_done;

  always_comb begin
    wbin_s   = g2b(wgray_s);
    occ      = wbin_s - rbin;           // pessimistic: write pointer is stale
    empty    = (occ == '0);
    low      = (occ < LOW_P);
    rbin_inc = rbin + PW'(1);
  end

  assign raddr = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_PRIME;
      rbin      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
      out_oct   <= '0;
      underflow <= 1'b0;
      ins_done  <= 1'b0;
    end else begin
      case (state)
        RD_PRIME: begin
          out_valid <= 1'b0;
          if (occ >= LOW_P) state <= RD_RUN;
        end
        RD_RUN: begin
          if (empty) begin
            out_valid <= 1'b0;
            underflow <= 1'b1;
          end else if (low && is_comma(head) && !ins_done) begin
            // Start an extra idle in front of the ordered set at the head.
            out_valid <= 1'b1;
            out_oct   <= '{k: 1'b1, d: COMMA_K285};
            ins_done  <= 1'b1;
            state     <= RD_INS;
          end else begin
            out_valid <= 1'b1;
            out_oct   <= head;
            rbin      <= rbin_inc;
            rgray     <= b2g(rbin_inc);
            ins_done  <= 1'b0;
          end
        end
        RD_INS: begin
          out_valid <= 1'b1;
          out_oct   <= '{k: 1'b0, d: idle_second(disp_on)};
          state     <= RD_RUN;
        end
        default: state <= RD_PRIME;
      endcase
    end
  end

  assert_rgray_step_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_rocc_bound_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= DEPTH_P);

  assert_ins_first_R6: assert property (@(posedge clk) disable iff (rst)
    (state == RD_INS) |-> (out_valid && is_comma(out_oct)));

  assert_ins_second_R6: assert property (@(posedge clk) disable iff (rst)
    (state == RD_INS) |=> (out_valid && !out_oct.k &&
                           (out_oct.d == idle_second($past(disp_on)))));

  assert_prime_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (state == RD_PRIME) |-> !out_valid);

  assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  assert_empty_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (state == RD_RUN && empty) |=> !out_valid);
endmodule

// File: rtl/idle_elastic_buf.sv
`timescale 1ns/1ps
// Per-port clock-correction buffer between a recovered receive clock and the
// core clock. Rate matching adds or drops whole idle ordered sets.
module idle_elastic_buf
  import eb_pkg::*;
#(
  parameter  int DEPTH       = 128,
  parameter  int HIGH_MARK   = 96,
  parameter  int LOW_MARK    = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH),
  localparam int PW          = AW + 1
) (
  input  logic       wr_clk,
  input  logic       wr_rst,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_is_k,
  input  logic       disp_chk,
  output logic       wr_overflow,
  input  logic       rd_clk,
  input  logic       rd_rst,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_is_k,
  output logic       rd_underflow
);
  octet_t        wr_oct, mem_wdata, mem_rdata, rd_oct;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          disp_w, disp_r;

  assign wr_oct = '{k: wr_is_k, d: wr_data};

  // Mode level brought into each domain.
  eb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_disp_w (
    .clk(wr_clk), .rst(wr_rst), .d(disp_chk), .q(disp_w));
  eb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_disp_r (
    .clk(rd_clk), .rst(rd_rst), .d(disp_chk), .q(disp_r));

  // Gray pointers crossing in both directions.
  eb_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s));
  eb_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s));

  eb_wr_ctrl #(.DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .in_valid(wr_valid), .in_oct(wr_oct),
    .disp_on(disp_w), .rgray_s(rgray_s), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wgray(wgray),
    .overflow(wr_overflow));

  eb_ram #(.DEPTH(DEPTH)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  eb_rd_ctrl #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .head(mem_rdata), .disp_on(disp_r),
    .wgray_s(wgray_s), .raddr(mem_raddr), .rgray(rgray),
    .out_valid(rd_valid), .out_oct(rd_oct), .underflow(rd_underflow));

  assign rd_data = rd_oct.d;
  assign rd_is_k = rd_oct.k;
endmodule

// File: tb/tb_idle_elastic_buf.sv
`timescale 1ns/1ps
module tb_idle_elastic_buf;
  localparam int DEPTH = 16;
  localparam int HI    = 11;
  localparam int LO    = 5;
  localparam int NGRP  = 40;   // groups: 6 data octets + 2 idles

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic wr_valid = 1'b0, wr_is_k = 1'b0, disp_chk = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_overflow, rd_valid, rd_is_k, rd_underflow;
  logic [7:0] rd_data;
  realtime rd_half = 5.0;

  always #5 wr_clk = ~wr_clk;          // 100 MHz write clock
  always #(rd_half) rd_clk = ~rd_clk;  // read clock varies per scenario

  idle_elastic_buf #(.DEPTH(DEPTH), .HIGH_MARK(HI), .LOW_MARK(LO),
                     .SYNC_STAGES(2)) dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_is_k(wr_is_k), .disp_chk(disp_chk), .wr_overflow(wr_overflow),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_is_k(rd_is_k), .rd_underflow(rd_underflow));

  int checks = 0, failures = 0;
  logic collect = 1'b0;
  int valid_seen = 0;
  logic [7:0] out_d[$];
  logic       out_k[$];
  logic [7:0] exp_q[$];

  always @(negedge rd_clk) begin
    if (collect && rd_valid) begin
      out_d.push_back(rd_data);
      out_k.push_back(rd_is_k);
      valid_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic put(input logic k, input logic [7:0] d);
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_is_k = k; wr_data = d;
  endtask

  task automatic stop_wr();
    @(negedge wr_clk);
    wr_valid = 1'b0; wr_is_k = 1'b0; wr_data = '0;
  endtask

  task automatic start(input logic mode, input realtime half);
    collect = 1'b0;
    rd_half = half;
    disp_chk = mode;
    wr_valid = 1'b0;
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk) wr_rst = 1'b0;
    @(negedge rd_clk) rd_rst = 1'b0;
    out_d.delete(); out_k.delete(); exp_q.delete();
    valid_seen = 0;
    collect = 1'b1;
  endtask

  // Data groups with two idles each; a trailing dummy octet flushes the
  // look-ahead register and is not expected at the output.
  task automatic send_groups(input int n, input logic [7:0] sec);
    for (int g = 0; g < n; g++) begin
      for (int i = 0; i < 6; i++) begin
        put(1'b0, 8'(g * 6 + i));
        exp_q.push_back(8'(g * 6 + i));
      end
      for (int j = 0; j < 2; j++) begin
        put(1'b1, 8'hBC);
        put(1'b0, sec);
      end
    end
    put(1'b0, 8'hEE);
    stop_wr();
  endtask

  task automatic drain();
    repeat (300) @(posedge rd_clk);
    @(negedge rd_clk);
  endtask

  // Splits the output into idles (by type) and data; counts broken pairs
  // and data mismatches against the expected queue.
  task automatic analyze(output int p1, output int p2, output int bad,
                         output int mism, output int nact);
    int i;
    p1 = 0; p2 = 0; bad = 0; mism = 0; nact = 0; i = 0;
    while (i < out_d.size()) begin
      if (out_k[i]) begin
        if (out_d[i] == 8'hBC && i + 1 < out_d.size() && !out_k[i+1] &&
            (out_d[i+1] == 8'hC5 || out_d[i+1] == 8'h50)) begin
          if (out_d[i+1] == 8'hC5) p1++; else p2++;
          i += 2;
        end else begin
          bad++; i++;
        end
      end else begin
        if (nact < exp_q.size() && out_d[i] != exp_q[nact]) mism++;
        nact++; i++;
      end
    end
  endtask

  int p1, p2, bad, mism, nact;

  initial begin
    // R1: reset state
    start(1'b0, 5.0);
    @(negedge rd_clk);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);
    chk(rd_is_k == 1'b0, "R1 rd_is_k", int'(rd_is_k), 0);
    chk(wr_overflow == 1'b0, "R1 wr_overflow", int'(wr_overflow), 0);
    chk(rd_underflow == 1'b0, "R1 rd_underflow", int'(rd_underflow), 0);

    // R7 priming, R2 exact transfer at equal rates, R8 underflow on drain
    // (R9: every transfer below relies on the Gray pointer crossing)
    for (int i = 1; i <= 3; i++) begin
      put(1'b0, 8'(i)); exp_q.push_back(8'(i));
    end
    stop_wr();
    repeat (30) @(negedge rd_clk);
    chk(valid_seen == 0, "R7 quiet below low mark", valid_seen, 0);
    for (int i = 0; i < 60; i++) begin
      put(1'b0, 8'(8'h40 + i)); exp_q.push_back(8'(8'h40 + i));
    end
    put(1'b0, 8'hEE);
    stop_wr();
    drain();
    analyze(p1, p2, bad, mism, nact);
    chk(valid_seen > 0, "R7 starts after low mark", valid_seen, 63);
    chk(nact == 63, "R2 octet count", nact, 63);
    chk(mism == 0, "R2 order and content", mism, 0);
    chk(p1 + p2 + bad == 0, "R2 no control added", p1 + p2 + bad, 0);
    chk(rd_underflow == 1'b1, "R8 underflow sticky", int'(rd_underflow), 1);
    chk(rd_valid == 1'b0, "R8 valid low when empty", int'(rd_valid), 0);

    // R4 deletion of /I1/ with a slow reader, mode 0
    start(1'b0, 5.5);
    send_groups(NGRP, 8'hC5);
    chk(wr_overflow == 1'b0, "R4 mode0 no overflow", int'(wr_overflow), 0);
    drain();
    analyze(p1, p2, bad, mism, nact);
    chk(bad == 0, "R10 pairs whole (delete I1)", bad, 0);
    chk(nact == NGRP * 6 && mism == 0, "R4 mode0 data intact", mism, 0);
    chk(p1 < NGRP * 2, "R4 mode0 idles deleted", p1, NGRP * 2 - 1);
    chk(p2 == 0, "R4 mode0 no I2 appears", p2, 0);

    // R4 deletion of /I2/ with a slow reader, mode 1
    start(1'b1, 5.5);
    send_groups(NGRP, 8'h50);
    chk(wr_overflow == 1'b0, "R4 mode1 no overflow", int'(wr_overflow), 0);
    drain();
    analyze(p1, p2, bad, mism, nact);
    chk(bad == 0, "R10 pairs whole (delete I2)", bad, 0);
    chk(nact == NGRP * 6 && mism == 0, "R4 mode1 data intact", mism, 0);
    chk(p2 < NGRP * 2, "R4 mode1 idles deleted", p2, NGRP * 2 - 1);
    chk(p1 == 0, "R4 mode1 no I1 appears", p1, 0);

    // R5 wrong idle type is kept, so the buffer overflows (R3 flag)
    start(1'b0, 5.5);
    send_groups(NGRP, 8'h50);
    chk(wr_overflow == 1'b1, "R5 I2 not deleted in mode0", int'(wr_overflow), 1);
    drain();
    chk(wr_overflow == 1'b1, "R3 overflow sticky", int'(wr_overflow), 1);

    // R6 insertion of /I1/ with a fast reader, mode 0
    start(1'b0, 4.0);
    send_groups(NGRP, 8'hC5);
    chk(rd_underflow == 1'b0, "R6 mode0 no underflow", int'(rd_underflow), 0);
    drain();
    analyze(p1, p2, bad, mism, nact);
    chk(bad == 0, "R10 pairs whole (insert I1)", bad, 0);
    chk(nact == NGRP * 6 && mism == 0, "R6 mode0 data intact", mism, 0);
    chk(p1 > NGRP * 2, "R6 mode0 idles inserted", p1, NGRP * 2 + 1);
    chk(p2 == 0, "R6 mode0 inserts only I1", p2, 0);

    // R6 mode 1 inserts /I2/ even though the input carries only /I1/
    start(1'b1, 4.0);
    send_groups(NGRP, 8'hC5);
    chk(rd_underflow == 1'b0, "R6 mode1 no underflow", int'(rd_underflow), 0);
    drain();
    analyze(p1, p2, bad, mism, nact);
    chk(bad == 0, "R10 pairs whole (insert I2)", bad, 0);
    chk(nact == NGRP * 6 && mism == 0, "R6 mode1 data intact", mism, 0);
    chk(p1 == NGRP * 2, "R6 mode1 input idles kept", p1, NGRP * 2);
    chk(p2 > 0, "R6 mode1 inserts I2", p2, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule